// File: doc/BRIEF.md
# QRSS Loopback Self-Test Engine

This block runs a built-in self-test of a serial transmit/receive data path. While the test enable is high, the block ignores the external transmit data. It drives the transmit bit from an internal quasi-random signal source (QRSS) instead. The pattern is a 20-stage maximal-length sequence with long zero runs broken up. The path under test returns the bit stream, and the block feeds it to a detector. The detector first loads its own copy of the sequence from the incoming bits. It then runs freely and compares each predicted bit against the bit received. The pattern generator and the detector advance only on cycles where the line-rate clock enable is high.

When the detector has seen 32 matching bits in a row, it declares lock. In the same clock edge, three status flags rise (transmit pattern active, receive lock, self-test pass) and the active-low interrupt request is latched low. Too many errors in a sliding 32-bit window drop the receive and pass flags, and the detector then starts to reacquire. The external positive and negative transmit data inputs must stay at zero during the test. Any nonzero value counts as a violation and restarts the test. Clearing the enable puts every flag back to zero and releases the interrupt request.

Top module: `qrss_bist`

## Requirements
- R1: While `bist_en` is low, `tx_bit` equals `tx_pos_in`, all three flags are 0 and `irq_n` is 1; the same holds in reset.
- R2: While `bist_en` is high, `tx_bit` is the generated pattern. Before the first enabled `line_ce`, it shows 1. The state s[19:0] starts at 20'h00001, with s[0] the newest bit. Each enabled `line_ce` edge computes raw = s[19] XOR s[16] and shifts s to {s[18:0], raw}. The output is 1 if raw is 0 and the 14 preceding outputs were all 0; otherwise it is raw.
- R3: The transmitted pattern never contains more than 14 consecutive zeros. Starting from the seed, the first run is exactly 14 zeros long.
- R4: After enable, the detector loads 20 received bits and then needs 32 consecutive matching bits before it declares lock. Lock therefore never comes earlier than 52 `line_ce` cycles after enable.
- R5: On the clock edge that declares lock, `rx_lock_flag`, `tx_qrss_flag` and `bist_pass_flag` become 1 together, and `irq_n` becomes 0.
- R6: Lock is held as long as every window of 32 consecutive received bits holds at most 3 errors (for example, one error every 11 bits).
- R7: At the edge that samples a 4th error within 32 consecutive received bits, `rx_lock_flag` and `bist_pass_flag` clear. `tx_qrss_flag` stays 1, `irq_n` stays 0, and the detector reacquires.
- R8: Any clock with `bist_en` high and `tx_pos_in` or `tx_neg_in` high is a violation. At the next edge, all three flags are 0 and the detector restarts. `irq_n` keeps its value.
- R9: At the first edge that samples `bist_en` low, all flags clear, `irq_n` returns to 1 and the generator is reseeded.
- R10: On cycles with `line_ce` low, neither the generator nor the detector advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bist_en | input | 1 | Self-test enable |
| line_ce | input | 1 | Line-rate clock enable, one bit per high cycle |
| rx_bit | input | 1 | Looped-back receive bit |
| tx_pos_in | input | 1 | External positive transmit data (must be 0 during test) |
| tx_neg_in | input | 1 | External negative transmit data (must be 0 during test) |
| tx_bit | output | 1 | Transmit bit: pattern when enabled, `tx_pos_in` otherwise |
| tx_qrss_flag | output | 1 | Transmit pattern flag |
| rx_lock_flag | output | 1 | Receive pattern lock flag |
| bist_pass_flag | output | 1 | Self-test pass flag |
| irq_n | output | 1 | Latched active-low interrupt request |

## Verification
A new pattern bit appears on `tx_bit` right after the clock edge that samples `line_ce` high. Status and interrupt changes caused by lock, by a 4th windowed error, by a violation or by a cleared enable become visible after that same edge. The bench drives inputs on the falling edge, waits for one rising edge, and compares on the next falling edge against its own sequence model and window arithmetic. The loopback delay line in the bench shifts only on `line_ce`. Error injection therefore lands on exact received-bit positions, which makes the 3-in-32 and 4-in-32 cases exact.

// File: rtl/qrss_pkg.sv
package qrss_pkg;
  localparam int unsigned PRBS_LEN     = 20;
  localparam int unsigned PRBS_TAP     = 17;
  localparam int unsigned MAX_ZERO_RUN = 14;
  localparam int unsigned LOCK_RUN     = 32;
  localparam int unsigned ERR_WIN      = 32;
  localparam int unsigned ERR_LIMIT    = 4;

  typedef enum logic [1:0] {
    DET_FILL = 2'd0,
    DET_HUNT = 2'd1,
    DET_LOCK = 2'd2
  } det_state_e;
endpackage

// File: rtl/qrss_prbs_gen.sv
module qrss_prbs_gen #(
  parameter int unsigned LEN      = qrss_pkg::PRBS_LEN,
  parameter int unsigned TAP      = qrss_pkg::PRBS_TAP,
  parameter int unsigned MAX_ZERO = qrss_pkg::MAX_ZERO_RUN,
  parameter logic [LEN-1:0] SEED  = 'd1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ce,
  output logic out_bit
);
  localparam int unsigned ZW = $clog2(MAX_ZERO + 1);

  logic [LEN-1:0] state_q, state_d;
  logic [ZW-1:0]  zrun_q, zrun_d;
  logic           out_q, out_d;
  logic           raw, force_one, nxt_out;

  always_comb begin
    raw       = state_q[LEN-1] ^ state_q[TAP-1];
    force_one = !raw && (zrun_q >= ZW'(MAX_ZERO));
    nxt_out   = raw | force_one;
    state_d   = state_q;
    zrun_d    = zrun_q;
    out_d     = out_q;
    if (!en) begin
      state_d = SEED;
      zrun_d  = '0;
      out_d   = 1'b1;
    end else if (ce) begin
      state_d = {state_q[LEN-2:0], raw};
      out_d   = nxt_out;
      zrun_d  = nxt_out ? '0 : zrun_q + ZW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
      zrun_q  <= '0;
      out_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      zrun_q  <= zrun_d;
      out_q   <= out_d;
    end
  end

  assign out_bit = out_q;
endmodule

// File: rtl/qrss_detector.sv
module qrss_detector #(
  parameter int unsigned LEN       = qrss_pkg::PRBS_LEN,
  parameter int unsigned TAP       = qrss_pkg::PRBS_TAP,
  parameter int unsigned MAX_ZERO  = qrss_pkg::MAX_ZERO_RUN,
  parameter int unsigned LOCK_RUN  = qrss_pkg::LOCK_RUN,
  parameter int unsigned ERR_WIN   = qrss_pkg::ERR_WIN,
  parameter int unsigned ERR_LIMIT = qrss_pkg::ERR_LIMIT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic ce,
  input  logic rx_bit,
  output logic locked,
  output logic lock_evt
);
  import qrss_pkg::*;

  localparam int unsigned ZW   = $clog2(MAX_ZERO + 1);
  localparam int unsigned CMAX = (LEN > LOCK_RUN) ? LEN : LOCK_RUN;
  localparam int unsigned CW   = $clog2(CMAX + 1);

  det_state_e       state_q, state_d;
  logic [LEN-1:0]   hist_q, hist_d;
  logic [ZW-1:0]    zrun_q, zrun_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [ERR_WIN-2:0] errw_q, errw_d;
  logic             raw_pred, pred, mismatch, window_bad;
  logic [ZW-1:0]    zrun_rx, zrun_pred;

  always_comb begin
    raw_pred   = hist_q[LEN-1] ^ hist_q[TAP-1];
    pred       = raw_pred | (zrun_q >= ZW'(MAX_ZERO));
    mismatch   = pred ^ rx_bit;
    window_bad = $countones({errw_q, mismatch}) >= ERR_LIMIT;
    zrun_rx    = rx_bit ? '0 : ((zrun_q >= ZW'(MAX_ZERO)) ? zrun_q : zrun_q + ZW'(1));
    zrun_pred  = pred ? '0 : zrun_q + ZW'(1);
  end

  always_comb begin
    state_d  = state_q;
    hist_d   = hist_q;
    zrun_d   = zrun_q;
    cnt_d    = cnt_q;
    errw_d   = errw_q;
    lock_evt = 1'b0;
    if (restart) begin
      state_d = DET_FILL;
      zrun_d  = '0;
      cnt_d   = '0;
      errw_d  = '0;
    end else if (ce) begin
      case (state_q)
        DET_FILL: begin
          hist_d = {hist_q[LEN-2:0], rx_bit};
          zrun_d = zrun_rx;
          cnt_d  = cnt_q + CW'(1);
          if (cnt_q == CW'(LEN - 1)) begin
            state_d = DET_HUNT;
            cnt_d   = '0;
          end
        end
        DET_HUNT: begin
          hist_d = {hist_q[LEN-2:0], raw_pred};
          zrun_d = zrun_pred;
          if (mismatch) begin
            state_d = DET_FILL;
            cnt_d   = '0;
            zrun_d  = '0;
          end else if (cnt_q == CW'(LOCK_RUN - 1)) begin
            state_d  = DET_LOCK;
            cnt_d    = '0;
            errw_d   = '0;
            lock_evt = 1'b1;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        default: begin
          hist_d = {hist_q[LEN-2:0], raw_pred};
          zrun_d = zrun_pred;
          errw_d = {errw_q[ERR_WIN-3:0], mismatch};
          if (window_bad) begin
            state_d = DET_FILL;
            cnt_d   = '0;
            zrun_d  = '0;
            errw_d  = '0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DET_FILL;
      hist_q  <= '0;
      zrun_q  <= '0;
      cnt_q   <= '0;
      errw_q  <= '0;
    end else begin
      state_q <= state_d;
      hist_q  <= hist_d;
      zrun_q  <= zrun_d;
      cnt_q   <= cnt_d;
      errw_q  <= errw_d;
    end
  end

  assign locked = (state_q == DET_LOCK);
endmodule

// File: rtl/qrss_status.sv
module qrss_status (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic viol,
  input  logic lock_evt,
  input  logic locked,
  output logic tx_flag,
  output logic rx_flag,
  output logic pass_flag,
  output logic irq_n
);
  logic tx_q, tx_d;
  logic irq_q, irq_d;

  always_comb begin
    tx_d  = tx_q;
    irq_d = irq_q;
    if (!en || viol) begin
      tx_d = 1'b0;
    end else if (lock_evt) begin
      tx_d = 1'b1;
    end
    if (!en) begin
      irq_d = 1'b1;
    end else if (lock_evt) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= 1'b0;
      irq_q <= 1'b1;
    end else begin
      tx_q  <= tx_d;
      irq_q <= irq_d;
    end
  end

  assign tx_flag   = tx_q;
  assign rx_flag   = locked;
  assign pass_flag = locked & tx_q;
  assign irq_n     = irq_q;
endmodule

// File: rtl/qrss_bist.sv
module qrss_bist #(
  parameter int unsigned PRBS_LEN  = qrss_pkg::PRBS_LEN,
  parameter int unsigned PRBS_TAP  = qrss_pkg::PRBS_TAP,
  parameter int unsigned MAX_ZERO  = qrss_pkg::MAX_ZERO_RUN,
  parameter int unsigned LOCK_RUN  = qrss_pkg::LOCK_RUN,
  parameter int unsigned ERR_WIN   = qrss_pkg::ERR_WIN,
  parameter int unsigned ERR_LIMIT = qrss_pkg::ERR_LIMIT,
  parameter logic [PRBS_LEN-1:0] SEED = 'd1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bist_en,
  input  logic line_ce,
  input  logic rx_bit,
  input  logic tx_pos_in,
  input  logic tx_neg_in,
  output logic tx_bit,
  output logic tx_qrss_flag,
  output logic rx_lock_flag,
  output logic bist_pass_flag,
  output logic irq_n
);
  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  logic       viol, det_restart, gen_bit, det_locked, det_lock_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  assign viol        = bist_en & (tx_pos_in | tx_neg_in);
  assign det_restart = !bist_en | viol;

  qrss_prbs_gen #(
    .LEN(PRBS_LEN), .TAP(PRBS_TAP), .MAX_ZERO(MAX_ZERO), .SEED(SEED)
  ) u_gen (
    .clk(clk), .rst_n(core_rst_n), .en(bist_en), .ce(line_ce), .out_bit(gen_bit)
  );

  qrss_detector #(
    .LEN(PRBS_LEN), .TAP(PRBS_TAP), .MAX_ZERO(MAX_ZERO),
    .LOCK_RUN(LOCK_RUN), .ERR_WIN(ERR_WIN), .ERR_LIMIT(ERR_LIMIT)
  ) u_det (
    .clk(clk), .rst_n(core_rst_n), .restart(det_restart), .ce(line_ce),
    .rx_bit(rx_bit), .locked(det_locked), .lock_evt(det_lock_evt)
  );

  qrss_status u_stat (
    .clk(clk), .rst_n(core_rst_n), .en(bist_en), .viol(viol),
    .lock_evt(det_lock_evt), .locked(det_locked),
    .tx_flag(tx_qrss_flag), .rx_flag(rx_lock_flag),
    .pass_flag(bist_pass_flag), .irq_n(irq_n)
  );

  assign tx_bit = bist_en ? gen_bit : tx_pos_in;
endmodule

// File: rtl/qrss_bist_chk.sv
module qrss_bist_chk #(
  parameter int unsigned MAX_ZERO = qrss_pkg::MAX_ZERO_RUN
) (
  input logic clk,
  input logic rst_n,
  input logic bist_en,
  input logic line_ce,
  input logic tx_pos_in,
  input logic tx_neg_in,
  input logic tx_bit,
  input logic tx_qrss_flag,
  input logic rx_lock_flag,
  input logic bist_pass_flag,
  input logic irq_n
);
  logic [7:0] zrun_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zrun_q <= '0;
    end else if (!bist_en) begin
      zrun_q <= '0;
    end else if (line_ce) begin
      if (tx_bit)               zrun_q <= '0;
      else if (zrun_q != 8'hFF) zrun_q <= zrun_q + 8'd1;
    end
  end

  // R3: a zero may only be sent while fewer than MAX_ZERO zeros precede it
  a_r3_zero_run: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_en && line_ce && !tx_bit) |-> (zrun_q < 8'(MAX_ZERO)));

  // R5: all lock indications appear together
  a_r5_flags_together: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_lock_flag) |-> (tx_qrss_flag && bist_pass_flag && !irq_n));

  // R7: loss of lock keeps the transmit flag and the latched request
  a_r7_loss_keeps_tx: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rx_lock_flag) && $past(bist_en) && !$past(tx_pos_in || tx_neg_in))
      |-> (tx_qrss_flag && !irq_n));

  // R8: a violation clears every flag at the next edge
  a_r8_violation_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_en && (tx_pos_in || tx_neg_in)) |=>
      (!rx_lock_flag && !tx_qrss_flag && !bist_pass_flag));

  // R9: a cleared enable returns all outputs to idle
  a_r9_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bist_en |=> (irq_n && !rx_lock_flag && !tx_qrss_flag && !bist_pass_flag));
endmodule

bind qrss_bist qrss_bist_chk #(.MAX_ZERO(MAX_ZERO)) u_chk (
  .clk(clk), .rst_n(rst_n), .bist_en(bist_en), .line_ce(line_ce),
  .tx_pos_in(tx_pos_in), .tx_neg_in(tx_neg_in), .tx_bit(tx_bit),
  .tx_qrss_flag(tx_qrss_flag), .rx_lock_flag(rx_lock_flag),
  .bist_pass_flag(bist_pass_flag), .irq_n(irq_n)
);

// File: tb/qrss_bist_tb.sv
`timescale 1ns/1ps
module qrss_bist_tb;
  localparam int LOOP_DLY = 5;

  logic clk, rst_n, bist_en, line_ce, rx_bit, tx_pos_in, tx_neg_in, flip;
  logic tx_bit, tx_qrss_flag, rx_lock_flag, bist_pass_flag, irq_n;
  logic [LOOP_DLY-1:0] lb_q;

  int n_chk, n_err, zr, zmax;
  bit done;
  logic [19:0] ref_state;
  int ref_zrun;
  logic ref_out;

  qrss_bist u_dut (
    .clk(clk), .rst_n(rst_n), .bist_en(bist_en), .line_ce(line_ce),
    .rx_bit(rx_bit), .tx_pos_in(tx_pos_in), .tx_neg_in(tx_neg_in),
    .tx_bit(tx_bit), .tx_qrss_flag(tx_qrss_flag), .rx_lock_flag(rx_lock_flag),
    .bist_pass_flag(bist_pass_flag), .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lb_q <= '0;
    else if (line_ce) lb_q <= {lb_q[LOOP_DLY-2:0], tx_bit};
  end
  assign rx_bit = lb_q[LOOP_DLY-1] ^ flip;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ref_reset();
    ref_state = 20'h00001;
    ref_zrun  = 0;
    ref_out   = 1'b1;
  endtask

  task automatic ref_step();
    logic raw, o;
    raw = ref_state[19] ^ ref_state[16];
    o = (!raw && ref_zrun >= 14) ? 1'b1 : raw;
    ref_state = {ref_state[18:0], raw};
    ref_out = o;
    ref_zrun = o ? 0 : ref_zrun + 1;
  endtask

  // one clock: drive at falling edge, compare transmit bit at next falling edge (R2 R10)
  task automatic tick(input logic ce_v, input logic flip_v);
    line_ce = ce_v;
    flip    = flip_v;
    @(posedge clk);
    if (!bist_en)   ref_reset();
    else if (ce_v)  ref_step();
    @(negedge clk);
    chk("R2 R10 tx_bit", tx_bit, bist_en ? ref_out : tx_pos_in);
    if (bist_en && ce_v) begin
      zr = tx_bit ? 0 : zr + 1;
      if (zr > zmax) zmax = zr;
    end
  endtask

  task automatic wait_lock(input int limit, output int n_ce);
    n_ce = 0;
    for (int i = 0; i < limit; i++) begin
      logic c;
      c = ($urandom % 4) != 0;
      tick(c, 1'b0);
      if (c) n_ce++;
      if (rx_lock_flag) break;
    end
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual 0 expected 1");
      finish_up();
    end
  end

  initial begin
    int n_ce;
    bit held;
    void'($urandom(32'h5EED));
    n_chk = 0; n_err = 0; zr = 0; zmax = 0; done = 0;
    rst_n = 1'b0; bist_en = 1'b0; line_ce = 1'b0; flip = 1'b0;
    tx_pos_in = 1'b0; tx_neg_in = 1'b0;
    ref_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset rx", rx_lock_flag, 0);
    chk("R1 reset tx flag", tx_qrss_flag, 0);
    chk("R1 reset pass", bist_pass_flag, 0);
    chk("R1 reset irq", irq_n, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: pass-through while disabled
    tx_pos_in = 1'b1;
    tick(1'b1, 1'b0);
    chk("R1 passthrough", tx_bit, 1);
    tx_pos_in = 1'b0;
    tick(1'b1, 1'b0);

    // R2: enable, first bit before any line_ce is 1
    bist_en = 1'b1;
    tick(1'b0, 1'b0);
    chk("R2 first bit", tx_bit, 1);

    // R4 R5: acquisition
    wait_lock(4000, n_ce);
    chk("R4 locked", rx_lock_flag, 1);
    chk("R4 lock not before 52 bits", (n_ce >= 52), 1);
    chk("R5 tx flag", tx_qrss_flag, 1);
    chk("R5 pass flag", bist_pass_flag, 1);
    chk("R5 irq", irq_n, 0);
    chk("R3 longest zero run", zmax, 14);

    // hold under clean loopback with random line_ce
    held = 1;
    for (int i = 0; i < 300; i++) begin
      tick(($urandom % 3) != 0, 1'b0);
      if (!rx_lock_flag) held = 0;
    end
    chk("R4 R10 lock held clean", held, 1);

    // R6: one error every 11 bits keeps lock
    held = 1;
    for (int k = 0; k < 8; k++) begin
      tick(1'b1, 1'b1);
      for (int j = 0; j < 10; j++) tick(1'b1, 1'b0);
      if (!rx_lock_flag) held = 0;
    end
    chk("R6 sparse errors keep lock", held, 1);
    for (int j = 0; j < 40; j++) tick(1'b1, 1'b0);

    // R7: errors every 10 bits, 4th within window drops lock
    for (int k = 0; k < 3; k++) begin
      tick(1'b1, 1'b1);
      for (int j = 0; j < 9; j++) tick(1'b1, 1'b0);
    end
    chk("R7 three errors still locked", rx_lock_flag, 1);
    tick(1'b1, 1'b1);
    chk("R7 rx cleared", rx_lock_flag, 0);
    chk("R7 pass cleared", bist_pass_flag, 0);
    chk("R7 tx flag kept", tx_qrss_flag, 1);
    chk("R7 irq kept", irq_n, 0);
    wait_lock(4000, n_ce);
    chk("R7 reacquired", rx_lock_flag, 1);

    // R8: violation on the negative input
    tx_neg_in = 1'b1;
    tick(1'b1, 1'b0);
    tx_neg_in = 1'b0;
    chk("R8 rx cleared", rx_lock_flag, 0);
    chk("R8 tx flag cleared", tx_qrss_flag, 0);
    chk("R8 pass cleared", bist_pass_flag, 0);
    chk("R8 irq unchanged", irq_n, 0);
    wait_lock(4000, n_ce);
    chk("R8 relock", rx_lock_flag, 1);
    tx_pos_in = 1'b1;
    tick(1'b0, 1'b0);
    tx_pos_in = 1'b0;
    chk("R8 positive input violation", tx_qrss_flag, 0);
    wait_lock(4000, n_ce);
    chk("R8 relock after positive", rx_lock_flag, 1);

    // R9: clear enable
    bist_en = 1'b0;
    tick(1'b1, 1'b0);
    chk("R9 rx", rx_lock_flag, 0);
    chk("R9 tx flag", tx_qrss_flag, 0);
    chk("R9 pass", bist_pass_flag, 0);
    chk("R9 irq released", irq_n, 1);
    bist_en = 1'b1;
    tick(1'b0, 1'b0);
    chk("R9 reseeded first bit", tx_bit, 1);
    for (int i = 0; i < 100; i++) tick(($urandom % 2) != 0, 1'b0);

    done = 1;
    finish_up();
  end
endmodule